// File: doc/BRIEF.md
# Frame-Buffer Refill and Write Arbiter

This block shares a single memory command port between two clients of a frame buffer. One client is the display side. A pixel FIFO feeds the scan-out logic, and that FIFO must never run dry. The other client is a queue of pending pixel writes. Each entry in that queue carries a word address and one 16-bit pixel. The arbiter watches the fill count of the display FIFO. When the count drops under half of the FIFO depth, the arbiter fetches four consecutive pixels from memory and pushes them into the display FIFO. When the display side has enough data, the arbiter pops one pending write and issues it to memory as a single-word store. Display refills always come first.

The arbiter keeps a running scan-out address. The address steps by one burst each time a refill completes, and it wraps back to pixel zero after the last pixel of the frame. A new-frame pulse from the display timing marks the end of the visible area. The pulse rewinds the scan-out address and empties the display FIFO. The arbiter issues one memory command at a time. If the pulse arrives while a command is in progress, the arbiter holds it until the command is finished.

The input queue is a show-ahead FIFO: `in_data` is valid whenever `in_empty` is low, and `in_rd_en` removes that entry.

Top module: `fb_fifo_arbiter`

## Requirements
- R1: After reset, no memory request, input pop, display push or flush is active, and the first refill reads from address 0.
- R2: In idle, when the display fill count is below HALF (half the display FIFO depth, 512 by default), the arbiter raises `mem_req` on the next cycle with `mem_we` = 0 and `mem_addr` equal to the scan-out address.
- R3: A refill wins over a pending write: with the fill count below HALF and the input FIFO non-empty, no entry is popped and a read is issued.
- R4: With the fill count at or above HALF and the input FIFO non-empty, the idle arbiter pulses `in_rd_en` for one cycle. On the next cycle it requests a write with `mem_we` = 1, `mem_addr` = entry bits [ADDR_W+15:16] and `mem_wdata` = entry bits [15:0].
- R5: After a read is acknowledged, each of the next four `mem_rvalid` cycles pushes `mem_rdata` into the display FIFO in the same cycle. After the fourth word the arbiter is idle again.
- R6: Only one command is in flight. `mem_req`, `mem_addr` and `mem_we` stay unchanged until `mem_ack`. No new decision is made until that acknowledge (for a write) or the fourth read word (for a read).
- R7: The scan-out address steps by 4 after every completed burst. It returns to 0 after the burst that holds pixel H_PIX*V_PIX-1.
- R8: A `frame_start` pulse seen while idle asserts `disp_flush` for exactly one cycle on the next cycle. No decision is made in that cycle, and the next refill reads from address 0.
- R9: A `frame_start` pulse during a command does not flush while the command runs. The flush happens in the first idle cycle after the command finishes, and the next refill reads from address 0.
- R10: With the fill count at or above HALF and the input FIFO empty, the arbiter stays idle with no request.
- R11: `mem_rvalid` outside the data phase of a read pushes nothing into the display FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_empty | input | 1 | Pending-write FIFO is empty |
| in_data | input | ADDR_W+16 | Head entry: address above, pixel in low 16 bits |
| in_rd_en | output | 1 | Pop the head entry of the pending-write FIFO |
| disp_level | input | $clog2(DISP_DEPTH)+1 | Display FIFO fill count |
| disp_wr_en | output | 1 | Push a pixel into the display FIFO |
| disp_wr_data | output | 16 | Pixel pushed into the display FIFO |
| disp_flush | output | 1 | Empty the display FIFO |
| frame_start | input | 1 | New-frame pulse from display timing |
| mem_req | output | 1 | Memory command request |
| mem_we | output | 1 | 1 = single-word write, 0 = four-word burst read |
| mem_addr | output | ADDR_W | Command word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Command accepted |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 16 | Read word |

## Verification
The bench uses a 16-pixel frame with an 8-bit address. This small frame lets nine refill bursts pass the wrap point twice. If the wrap used the wrong limit, or the step was not a full burst, the expected address would differ from `mem_addr`. The bench holds the fill count exactly at HALF and at HALF-1 while a write is pending. A comparator that was off by one would pop an entry when it should refill, or refill when it should write. The bench sends `frame_start` both in idle and in the middle of a burst. A design that flushed at once would clear the display FIFO while burst words were still landing, and one that dropped the pulse would keep reading from the old address. The bench also sends stray `mem_rvalid` outside a read and stretches acknowledge delays. These catch pushes of unrequested words and commands that change before they are accepted.

// File: rtl/fb_arb_pkg.sv
// Shared types for the frame-buffer arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package fb_arb_pkg;

    // Arbiter sequencing states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_CMD  = 2'd1,
        ST_RD_DATA = 2'd2,
        ST_WR_CMD  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/fb_read_ptr.sv
// Scan-out address counter: steps one burst per completed refill and
// wraps to zero after the burst holding the last pixel of the frame.
// Assumes: FRAME_PIX is a multiple of BURST and fits in ADDR_W bits.
module fb_read_ptr #(
    parameter int ADDR_W    = 24,
    parameter int FRAME_PIX = 640 * 480,
    parameter int BURST     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    localparam int LAST_START = FRAME_PIX - BURST;

    // Hold, rewind or step the scan-out address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (advance) begin
            if (addr == ADDR_W'(LAST_START)) begin
                addr <= '0;
            end else begin
                addr <= addr + ADDR_W'(BURST);
            end
        end
    end
endmodule

// File: rtl/fb_frame_hold.sv
// Holds a new-frame pulse until the arbiter is free to act on it.
// Assumes: take is asserted only in a cycle where the pending flag is set.
module fb_frame_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic take,
    output logic pending
);
    // Set on a pulse, clear once consumed (a fresh pulse wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else begin
            pending <= frame_start | (pending & ~take);
        end
    end
endmodule

// File: rtl/fb_arb_fsm.sv
// Decision and sequencing core: picks refill, write or frame handling in
// idle, then tracks one memory command to completion.
// Assumes: show-ahead input FIFO; mem_rvalid for a read arrives only after
// its mem_ack; a read returns exactly BURST words.
module fb_arb_fsm
    import fb_arb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PIX_W  = 16,
    parameter int LVL_W  = 11,
    parameter int HALF   = 512,
    parameter int BURST  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_pend,
    input  logic [LVL_W-1:0]        disp_level,
    input  logic                    in_empty,
    input  logic [ADDR_W+PIX_W-1:0] in_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    mem_ack,
    input  logic                    mem_rvalid,
    output logic                    in_rd_en,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [PIX_W-1:0]        mem_wdata,
    output logic                    disp_wr_en,
    output logic                    flush_take,
    output logic                    ptr_advance
);
    localparam int CNT_W = (BURST > 1) ? $clog2(BURST) : 1;

    arb_state_e       state;
    logic [CNT_W-1:0] beat;
    logic             idle;
    logic             lvl_low;
    logic             go_read;
    logic             last_word;

    // Decode of the current decision inputs
    always_comb begin
        idle       = (state == ST_IDLE);
        lvl_low    = (disp_level < LVL_W'(HALF));
        flush_take = idle && frame_pend;
        go_read    = idle && !frame_pend && lvl_low;
        in_rd_en   = idle && !frame_pend && !lvl_low && !in_empty;
        disp_wr_en = (state == ST_RD_DATA) && mem_rvalid;
        last_word  = disp_wr_en && (beat == CNT_W'(BURST - 1));
        ptr_advance = last_word;
        mem_req    = (state == ST_RD_CMD) || (state == ST_WR_CMD);
        mem_we     = (state == ST_WR_CMD);
    end

    // State sequencing: one command at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go_read) begin
                        state <= ST_RD_CMD;
                    end else if (in_rd_en) begin
                        state <= ST_WR_CMD;
                    end
                end
                ST_RD_CMD:  if (mem_ack) state <= ST_RD_DATA;
                ST_RD_DATA: if (last_word) state <= ST_IDLE;
                ST_WR_CMD:  if (mem_ack) state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Burst word counter for the read data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (state == ST_RD_CMD) begin
            beat <= '0;
        end else if (disp_wr_en) begin
            beat <= beat + CNT_W'(1);
        end
    end

    // Command address and write data captured at the decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (go_read) begin
            mem_addr  <= rd_addr;
        end else if (in_rd_en) begin
            mem_addr  <= in_data[PIX_W +: ADDR_W];
            mem_wdata <= in_data[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/fb_fifo_arbiter.sv
// Frame-buffer arbiter top: shares one memory command port between
// display refills (four-word bursts, strict priority) and single-pixel
// writes, and applies new-frame rewinds at command boundaries.
// Assumes: DISP_DEPTH is even; FIFOs and memory controller live outside.
module fb_fifo_arbiter #(
    parameter int ADDR_W     = 24,
    parameter int PIX_W      = 16,
    parameter int H_PIX      = 640,
    parameter int V_PIX      = 480,
    parameter int DISP_DEPTH = 1024,
    parameter int BURST      = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_empty,
    input  logic [ADDR_W+PIX_W-1:0]        in_data,
    output logic                           in_rd_en,
    input  logic [$clog2(DISP_DEPTH):0]    disp_level,
    output logic                           disp_wr_en,
    output logic [PIX_W-1:0]               disp_wr_data,
    output logic                           disp_flush,
    input  logic                           frame_start,
    output logic                           mem_req,
    output logic                           mem_we,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [PIX_W-1:0]               mem_wdata,
    input  logic                           mem_ack,
    input  logic                           mem_rvalid,
    input  logic [PIX_W-1:0]               mem_rdata
);
    localparam int LVL_W     = $clog2(DISP_DEPTH) + 1;
    localparam int HALF      = DISP_DEPTH / 2;
    localparam int FRAME_PIX = H_PIX * V_PIX;

    logic              frame_pend;
    logic              flush_take;
    logic              ptr_advance;
    logic [ADDR_W-1:0] rd_addr;

    fb_frame_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .take        (flush_take),
        .pending     (frame_pend)
    );

    fb_read_ptr #(
        .ADDR_W    (ADDR_W),
        .FRAME_PIX (FRAME_PIX),
        .BURST     (BURST)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (flush_take),
        .advance (ptr_advance),
        .addr    (rd_addr)
    );

    fb_arb_fsm #(
        .ADDR_W (ADDR_W),
        .PIX_W  (PIX_W),
        .LVL_W  (LVL_W),
        .HALF   (HALF),
        .BURST  (BURST)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pend  (frame_pend),
        .disp_level  (disp_level),
        .in_empty    (in_empty),
        .in_data     (in_data),
        .rd_addr     (rd_addr),
        .mem_ack     (mem_ack),
        .mem_rvalid  (mem_rvalid),
        .in_rd_en    (in_rd_en),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .disp_wr_en  (disp_wr_en),
        .flush_take  (flush_take),
        .ptr_advance (ptr_advance)
    );

    // Read words pass straight through to the display FIFO
    assign disp_wr_data = mem_rdata;
    assign disp_flush   = flush_take;
endmodule

// File: rtl/fb_arb_checker.sv
// Protocol checks for the frame-buffer arbiter, bound to its top.
// Assumes: connected to the top-level ports only.
module fb_arb_checker #(
    parameter int ADDR_W = 24,
    parameter int LVL_W  = 11,
    parameter int HALF   = 512,
    parameter int BURST  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_empty,
    input logic              in_rd_en,
    input logic [LVL_W-1:0]  disp_level,
    input logic              disp_wr_en,
    input logic              disp_flush,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              mem_rvalid
);
    p_read_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && !mem_we) |-> ($past(disp_level) < LVL_W'(HALF)));

    p_pop_needs_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd_en |-> (disp_level >= LVL_W'(HALF)));

    p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd_en |-> !in_empty);

    p_pop_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd_en |=> (mem_req && mem_we));

    p_push_in_data_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_wr_en |-> (mem_rvalid && !mem_req));

    p_cmd_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_read_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> ((mem_addr & ADDR_W'(BURST - 1)) == '0));

    p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_flush |-> (!mem_req && !disp_wr_en && !in_rd_en));

    p_flush_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_flush |=> !mem_req);
endmodule

bind fb_fifo_arbiter fb_arb_checker #(
    .ADDR_W (ADDR_W),
    .LVL_W  (LVL_W),
    .HALF   (HALF),
    .BURST  (BURST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_empty   (in_empty),
    .in_rd_en   (in_rd_en),
    .disp_level (disp_level),
    .disp_wr_en (disp_wr_en),
    .disp_flush (disp_flush),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rvalid (mem_rvalid)
);

// File: tb/fb_fifo_arbiter_test.sv
module fb_fifo_arbiter_test;
    localparam int ADDR_W = 8;
    localparam int PIX_W  = 16;
    localparam int H_PIX  = 8;
    localparam int V_PIX  = 2;
    localparam int DEPTH  = 16;
    localparam int BURST  = 4;
    localparam int LVL_W  = $clog2(DEPTH) + 1;
    localparam int HALF   = DEPTH / 2;
    localparam int FRAME  = H_PIX * V_PIX;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_empty = 1'b1;
    logic [ADDR_W+PIX_W-1:0] in_data = '0;
    logic                    in_rd_en;
    logic [LVL_W-1:0]        disp_level = LVL_W'(HALF);
    logic                    disp_wr_en;
    logic [PIX_W-1:0]        disp_wr_data;
    logic                    disp_flush;
    logic                    frame_start = 1'b0;
    logic                    mem_req;
    logic                    mem_we;
    logic [ADDR_W-1:0]       mem_addr;
    logic [PIX_W-1:0]        mem_wdata;
    logic                    mem_ack = 1'b0;
    logic                    mem_rvalid = 1'b0;
    logic [PIX_W-1:0]        mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int exp_addr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fb_fifo_arbiter #(
        .ADDR_W (ADDR_W), .PIX_W (PIX_W), .H_PIX (H_PIX), .V_PIX (V_PIX),
        .DISP_DEPTH (DEPTH), .BURST (BURST)
    ) uut (
        .clk (clk), .rst_n (rst_n), .in_empty (in_empty), .in_data (in_data),
        .in_rd_en (in_rd_en), .disp_level (disp_level), .disp_wr_en (disp_wr_en),
        .disp_wr_data (disp_wr_data), .disp_flush (disp_flush),
        .frame_start (frame_start), .mem_req (mem_req), .mem_we (mem_we),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_ack (mem_ack),
        .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance one clock, ending at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One refill burst from an idle start at a falling edge
    task automatic do_read(input int ack_wait, input int gap, input bit pend_write,
                           input bit frame_mid);
        disp_level = LVL_W'(HALF - 1);
        in_empty   = !pend_write;
        in_data    = 24'hAB_1234;
        #1;
        chk("R3 no pop while refill wanted", in_rd_en, 0);
        chk("R2 no request before decision", mem_req, 0);
        step();
        disp_level = LVL_W'(HALF);
        in_empty   = 1'b1;
        #1;
        chk("R2 read request", mem_req, 1);
        chk("R2 read direction", mem_we, 0);
        chk("R7 read address", mem_addr, exp_addr);
        for (int w = 0; w < ack_wait; w++) begin
            mem_rvalid = 1'b1;
            #1;
            chk("R11 no push before ack", disp_wr_en, 0);
            step();
            mem_rvalid = 1'b0;
            #1;
            chk("R6 request held", mem_req, 1);
            chk("R6 address held", mem_addr, exp_addr);
        end
        mem_ack = 1'b1;
        step();
        mem_ack = 1'b0;
        #1;
        chk("R6 request dropped after ack", mem_req, 0);
        for (int b = 0; b < BURST; b++) begin
            for (int g = 0; g < gap; g++) begin
                #1;
                chk("R5 no push without valid", disp_wr_en, 0);
                step();
            end
            mem_rvalid  = 1'b1;
            mem_rdata   = PIX_W'(16'hC000 + exp_addr * 16 + b);
            frame_start = frame_mid && (b == 1);
            #1;
            chk("R5 push on valid", disp_wr_en, 1);
            chk("R5 pushed data", disp_wr_data, 16'hC000 + exp_addr * 16 + b);
            chk("R9 no flush during burst", disp_flush, 0);
            step();
            mem_rvalid  = 1'b0;
            frame_start = 1'b0;
        end
        exp_addr = (exp_addr + BURST) % FRAME;
        #1;
        chk("R5 idle after burst", mem_req, 0);
        if (frame_mid) begin
            chk("R9 deferred flush", disp_flush, 1);
            step();
            #1;
            chk("R9 flush one cycle", disp_flush, 0);
            exp_addr = 0;
        end
    endtask

    // One pending write from an idle start at a falling edge
    task automatic do_write(input logic [23:0] entry, input int level, input int ack_wait);
        in_empty   = 1'b0;
        in_data    = entry;
        disp_level = LVL_W'(level);
        #1;
        chk("R4 pop at decision", in_rd_en, 1);
        chk("R4 no request yet", mem_req, 0);
        step();
        in_empty = 1'b1;
        #1;
        chk("R4 pop is one cycle", in_rd_en, 0);
        chk("R4 write request", mem_req, 1);
        chk("R4 write direction", mem_we, 1);
        chk("R4 write address", mem_addr, entry[23:16]);
        chk("R4 write data", mem_wdata, entry[15:0]);
        for (int w = 0; w < ack_wait; w++) begin
            mem_rvalid = 1'b1;
            #1;
            chk("R11 no push during write", disp_wr_en, 0);
            step();
            mem_rvalid = 1'b0;
            #1;
            chk("R6 write held", mem_req, 1);
            chk("R6 write address held", mem_addr, entry[23:16]);
        end
        mem_ack = 1'b1;
        step();
        mem_ack = 1'b0;
        disp_level = LVL_W'(HALF);
        #1;
        chk("R6 write done", mem_req, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        #1;
        chk("R1 reset no request", mem_req, 0);
        chk("R1 reset no pop", in_rd_en, 0);
        chk("R1 reset no push", disp_wr_en, 0);
        chk("R1 reset no flush", disp_flush, 0);
        rst_n = 1'b1;
        step();

        // R10: nothing to do
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R10 idle no request", mem_req, 0);
            chk("R10 idle no pop", in_rd_en, 0);
            step();
        end

        // R1/R2/R5/R6/R7: sweep bursts across two frame wraps
        for (int i = 0; i < 9; i++) begin
            do_read(i % 3, (i / 3) % 2, 1'b0, 1'b0);
        end

        // R3: refill beats a pending write at level HALF-1
        do_read(1, 0, 1'b1, 1'b0);

        // R4: writes at level HALF and above, with a stray valid (R11)
        for (int i = 0; i < 12; i++) begin
            do_write({8'(i * 21 + 3), 16'(16'h5A00 ^ (i * 16'h0111))},
                     HALF + (i % (DEPTH - HALF + 1)), i % 3);
        end

        // R11: stray valid while idle
        mem_rvalid = 1'b1;
        #1;
        chk("R11 no push while idle", disp_wr_en, 0);
        step();
        mem_rvalid = 1'b0;

        // R8: new frame in idle, address nonzero before
        do_read(0, 0, 1'b0, 1'b0);
        frame_start = 1'b1;
        #1;
        chk("R8 no flush same cycle", disp_flush, 0);
        step();
        frame_start = 1'b0;
        disp_level  = '0;
        in_empty    = 1'b0;
        #1;
        chk("R8 flush asserted", disp_flush, 1);
        chk("R8 no pop during flush", in_rd_en, 0);
        step();
        in_empty = 1'b1;
        #1;
        chk("R8 flush one cycle", disp_flush, 0);
        exp_addr = 0;
        do_read(0, 0, 1'b0, 1'b0);

        // R9: new frame during a burst
        do_read(1, 1, 1'b0, 1'b1);
        do_read(0, 0, 1'b0, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule